// File: doc/BRIEF.md
# Free-Running Timer with Toggle Compare Outputs

The block is a free-running up-counter with a set of compare channels (two by default). Software starts it by setting an enable bit through a small register write port. From then on the counter advances by one on every cycle where the count-clock strobe is high. When the counter wraps from its all-ones value back to zero, the block emits an overflow interrupt pulse and sets a sticky overflow flag. That flag stays set until software clears it.

Each channel holds a compare value. When the counter sits on that value at a count step, the channel emits a one-cycle interrupt pulse and inverts its output pin. Starting the timer inverts every output pin once, so a channel produces a square wave whose edges follow the compare points. Compare values may be rewritten while the timer runs and take effect at once, with no shadow register.

Top module: `toggle_compare_timer`

## Requirements
- R1: After reset, `tgl_o`, `cmp_irq_o`, `ovf_irq_o` and `ovf_flag_o` are all 0, and the counter is idle at zero.
- R2: A control write with bit 0 = 1 while the timer is stopped starts it from count 0 and inverts every `tgl_o` bit once at that edge. The same write while the timer is already running inverts nothing.
- R3: While running, the counter advances by exactly one on each cycle where `tick_i` is 1 and holds otherwise. A count value held across stalled cycles gives at most one match event.
- R4: On a cycle where `tick_i` is 1 and the count equals compare value n, `cmp_irq_o[n]` is 1 during the following cycle only, and `tgl_o[n]` inverts at the same edge. Each channel acts independently, and equal compare values fire together.
- R5: On a cycle where `tick_i` is 1 and the count is all ones, `ovf_irq_o` is 1 during the following cycle only and the counter reloads to 0. Counting continues, and the value 0 is compared at the next step.
- R6: `ovf_flag_o` rises together with `ovf_irq_o` and stays 1 until a control write with bit 1 = 1. If that clear lands in the same cycle as an overflow, the flag stays set.
- R7: A compare write is used for matching from the next cycle on. A count step in the write cycle itself is compared against the old value.
- R8: A control write with bit 0 = 0 stops the timer and returns the counter to 0, while `tgl_o` keeps its level.
- R9: The register map is as follows. Address 0 is control (bit 0 = enable, bit 1 = clear overflow flag). Address 1 holds the compare value of channel 0 and address 2 that of channel 1. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW (2) | Register address |
| wr_data_i | input | CNT_W (16) | Register write data |
| tick_i | input | 1 | Count-clock enable strobe |
| tgl_o | output | N_CH (2) | Toggle output per channel |
| cmp_irq_o | output | N_CH (2) | Compare interrupt pulse per channel |
| ovf_irq_o | output | 1 | Overflow interrupt pulse |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
Every result is registered. A compare pulse, its toggle, the overflow pulse and the flag change all show up right after the clock edge that samples the deciding tick, and a register write acts at the edge that takes it. The bench drives each stimulus just after a falling edge and advances one rising edge. At the next falling edge it compares all four outputs with the values its own arithmetic counter model gives for that exact cycle, so a result one cycle early or late is reported. The sweeps cover paired compare values, stalled tick patterns, mid-run compare rewrites and one full wrap of the 16-bit counter. The wrap run includes a flag clear that coincides with the overflow.

// File: rtl/tct_pkg.sv
package tct_pkg;
  localparam int CTRL_ADDR = 0;
  localparam int EN_BIT    = 0;
  localparam int CLR_BIT   = 1;

  function automatic int cmp_addr(input int ch);
    return ch + 1;
  endfunction
endpackage

// File: rtl/tct_counter.sv
module tct_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             en_bit_i,
  input  logic             clr_bit_i,
  input  logic             tick_i,
  output logic             run_o,
  output logic             start_o,
  output logic             step_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_irq_o,
  output logic             ovf_flag_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_irq_q;
  logic             flag_q;
  logic             wrap;

  assign start_o = ctrl_we_i & en_bit_i & ~run_q;
  assign step_o  = run_q & tick_i;
  assign wrap    = step_o && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      cnt_q     <= '0;
      ovf_irq_q <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      ovf_irq_q <= wrap;
      if (ctrl_we_i) run_q <= en_bit_i;
      if (ctrl_we_i && !en_bit_i) cnt_q <= '0;
      else if (step_o)            cnt_q <= cnt_q + CNT_ONE;
      // hardware set has priority over software clear
      if (wrap)                        flag_q <= 1'b1;
      else if (ctrl_we_i && clr_bit_i) flag_q <= 1'b0;
    end
  end

  assign run_o      = run_q;
  assign cnt_o      = cnt_q;
  assign ovf_irq_o  = ovf_irq_q;
  assign ovf_flag_o = flag_q;
endmodule

// File: rtl/tct_channel.sv
module tct_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_data_i,
  input  logic             step_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             tgl_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cmp_q;
  logic             tgl_q;
  logic             irq_q;
  logic             hit;

  // evaluated only on a count step, so a stalled value fires once
  assign hit = step_i && (cnt_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
      tgl_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (cmp_we_i) cmp_q <= cmp_data_i;
      irq_q <= hit;
      if (hit || start_i) tgl_q <= ~tgl_q;
    end
  end

  assign tgl_o = tgl_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/toggle_compare_timer.sv
module toggle_compare_timer
  import tct_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_CH  = 2,
  localparam int AW   = $clog2(N_CH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             tick_i,
  output logic [N_CH-1:0]  tgl_o,
  output logic [N_CH-1:0]  cmp_irq_o,
  output logic             ovf_irq_o,
  output logic             ovf_flag_o
);
  logic             ctrl_we_w;
  logic             clr_w;
  logic             run_w;
  logic             start_w;
  logic             step_w;
  logic [CNT_W-1:0] cnt_w;

  assign ctrl_we_w = wr_en_i && (wr_addr_i == AW'(CTRL_ADDR));
  assign clr_w     = ctrl_we_w && wr_data_i[CLR_BIT];

  tct_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (ctrl_we_w),
    .en_bit_i   (wr_data_i[EN_BIT]),
    .clr_bit_i  (wr_data_i[CLR_BIT]),
    .tick_i     (tick_i),
    .run_o      (run_w),
    .start_o    (start_w),
    .step_o     (step_w),
    .cnt_o      (cnt_w),
    .ovf_irq_o  (ovf_irq_o),
    .ovf_flag_o (ovf_flag_o)
  );

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    logic cmp_we;
    assign cmp_we = wr_en_i && (wr_addr_i == AW'(cmp_addr(n)));

    tct_channel #(.CNT_W(CNT_W)) u_channel (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cmp_we_i   (cmp_we),
      .cmp_data_i (wr_data_i),
      .step_i     (step_w),
      .start_i    (start_w),
      .cnt_i      (cnt_w),
      .tgl_o      (tgl_o[n]),
      .irq_o      (cmp_irq_o[n])
    );
  end
endmodule

// File: rtl/tct_checker.sv
module tct_checker #(
  parameter int CNT_W = 16,
  parameter int N_CH  = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             ctrl_we_i,
  input logic             clr_i,
  input logic             run_i,
  input logic             start_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [N_CH-1:0]  tgl_i,
  input logic [N_CH-1:0]  cmp_irq_i,
  input logic             ovf_irq_i,
  input logic             ovf_flag_i
);
  for (genvar n = 0; n < N_CH; n++) begin : g_chk
    p_irq_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmp_irq_i[n] |=> !cmp_irq_i[n]);
    p_irq_toggles_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmp_irq_i[n] |-> (tgl_i[n] != $past(tgl_i[n])));
    p_tgl_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tgl_i[n] != $past(tgl_i[n])) |-> (cmp_irq_i[n] || $past(start_i)));
  end

  p_ovf_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_i |=> !ovf_irq_i);
  p_ovf_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_i |-> ovf_flag_i);
  p_ovf_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_i |-> (cnt_i == '0));
  p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_i && !clr_i) |=> ovf_flag_i);
  p_stall_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i && !ctrl_we_i) |=> $stable(cnt_i));
  p_idle_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (cnt_i == '0));
endmodule

bind toggle_compare_timer tct_checker #(.CNT_W(CNT_W), .N_CH(N_CH)) u_tct_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .ctrl_we_i  (ctrl_we_w),
  .clr_i      (clr_w),
  .run_i      (run_w),
  .start_i    (start_w),
  .cnt_i      (cnt_w),
  .tgl_i      (tgl_o),
  .cmp_irq_i  (cmp_irq_o),
  .ovf_irq_i  (ovf_irq_o),
  .ovf_flag_i (ovf_flag_o)
);

// File: tb/toggle_compare_timer_bench.sv
`timescale 1ns/1ps
module toggle_compare_timer_bench;
  localparam int CLK_P = 10;
  localparam int WDOG  = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        tick = 1'b0;
  logic [1:0]  tgl;
  logic [1:0]  cmp_irq;
  logic        ovf_irq;
  logic        ovf_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // arithmetic model state
  bit          m_run = 1'b0;
  logic [15:0] m_cnt = '0;
  logic [15:0] m_cmp [2] = '{16'd0, 16'd0};
  logic [1:0]  m_tgl = '0;
  bit          m_flag = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  toggle_compare_timer u_toggle_compare_timer (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .tick_i     (tick),
    .tgl_o      (tgl),
    .cmp_irq_o  (cmp_irq),
    .ovf_irq_o  (ovf_irq),
    .ovf_flag_o (ovf_flag)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // drive after a falling edge, take one rising edge, check at the next falling edge
  task automatic step(input string tag, input logic tk, input logic we,
                      input logic [1:0] addr, input logic [15:0] data);
    logic [1:0] e_irq;
    logic       e_ovf;
    tick = tk; wr_en = we; wr_addr = addr; wr_data = data;
    @(posedge clk);
    @(negedge clk);
    e_irq = '0;
    e_ovf = 1'b0;
    if (m_run && tk) begin
      for (int n = 0; n < 2; n++)
        if (m_cnt == m_cmp[n]) begin
          e_irq[n] = 1'b1;
          m_tgl[n] = ~m_tgl[n];
        end
      if (m_cnt == 16'hFFFF) e_ovf = 1'b1;
      m_cnt = m_cnt + 16'd1;
    end
    if (we) begin
      if (addr == 2'd0) begin
        if (data[1]) m_flag = 1'b0;
        if (data[0] && !m_run) m_tgl = ~m_tgl;
        if (!data[0]) m_cnt = '0;
        m_run = data[0];
      end else if (addr == 2'd1) m_cmp[0] = data;
      else if (addr == 2'd2) m_cmp[1] = data;
    end
    if (e_ovf) m_flag = 1'b1;
    chk(tag, "cmp_irq", 32'(cmp_irq), 32'(e_irq));
    chk(tag, "ovf_irq", 32'(ovf_irq), 32'(e_ovf));
    chk(tag, "tgl", 32'(tgl), 32'(m_tgl));
    chk(tag, "ovf_flag", 32'(ovf_flag), 32'(m_flag));
    wr_en = 1'b0;
    tick = 1'b0;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (R1..R9 run) actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "tgl", 32'(tgl), 32'd0);
    chk("R1", "cmp_irq", 32'(cmp_irq), 32'd0);
    chk("R1", "ovf_irq", 32'(ovf_irq), 32'd0);
    chk("R1", "ovf_flag", 32'(ovf_flag), 32'd0);
    step("R1", 1'b1, 1'b0, 2'd0, 16'd0);

    // R4 sweep of compare pairs with a steady tick
    for (int c0 = 0; c0 < 8; c0++) begin
      step("R8", 1'b1, 1'b1, 2'd0, 16'd0);
      step("R9", 1'b0, 1'b1, 2'd1, 16'(c0));
      step("R9", 1'b0, 1'b1, 2'd2, 16'(7 - c0));
      step("R2", 1'b0, 1'b1, 2'd0, 16'd1);
      for (int i = 0; i < 11; i++) step("R4", 1'b1, 1'b0, 2'd0, 16'd0);
    end
    // equal compare values fire together
    step("R8", 1'b0, 1'b1, 2'd0, 16'd0);
    step("R9", 1'b0, 1'b1, 2'd1, 16'd4);
    step("R9", 1'b0, 1'b1, 2'd2, 16'd4);
    step("R2", 1'b0, 1'b1, 2'd0, 16'd1);
    for (int i = 0; i < 8; i++) step("R4", 1'b1, 1'b0, 2'd0, 16'd0);
    // rewriting enable while running, and an unused address
    step("R2", 1'b1, 1'b1, 2'd0, 16'd1);
    step("R9", 1'b1, 1'b1, 2'd3, 16'hFFFF);
    step("R9", 1'b0, 1'b1, 2'd3, 16'h0002);

    // R3 stalled tick patterns
    for (int p = 2; p < 5; p++) begin
      step("R8", 1'b0, 1'b1, 2'd0, 16'd0);
      step("R3", 1'b0, 1'b1, 2'd1, 16'd3);
      step("R3", 1'b0, 1'b1, 2'd2, 16'd6);
      step("R2", 1'b0, 1'b1, 2'd0, 16'd1);
      for (int i = 0; i < 30; i++) step("R3", 1'b1 ^ ((i % p) == 0), 1'b0, 2'd0, 16'd0);
    end

    // R7 compare rewrites while running
    step("R8", 1'b0, 1'b1, 2'd0, 16'd0);
    step("R7", 1'b0, 1'b1, 2'd1, 16'd200);
    step("R7", 1'b0, 1'b1, 2'd2, 16'd300);
    step("R2", 1'b0, 1'b1, 2'd0, 16'd1);
    for (int i = 0; i < 5; i++) step("R7", 1'b1, 1'b0, 2'd0, 16'd0);
    step("R7", 1'b1, 1'b1, 2'd1, 16'd6);
    step("R7", 1'b1, 1'b0, 2'd0, 16'd0);
    step("R7", 1'b1, 1'b1, 2'd2, 16'd7);
    for (int i = 0; i < 4; i++) step("R7", 1'b1, 1'b0, 2'd0, 16'd0);
    // R8 stop holds levels
    step("R8", 1'b1, 1'b1, 2'd0, 16'd0);
    for (int i = 0; i < 3; i++) step("R8", 1'b1, 1'b0, 2'd0, 16'd0);

    // R5 R6 full wrap, clear coinciding with overflow
    step("R5", 1'b0, 1'b1, 2'd1, 16'd0);
    step("R5", 1'b0, 1'b1, 2'd2, 16'hFFFF);
    step("R2", 1'b0, 1'b1, 2'd0, 16'd1);
    for (int i = 0; i < 65535; i++) step("R5", 1'b1, 1'b0, 2'd0, 16'd0);
    step("R6", 1'b1, 1'b1, 2'd0, 16'd3);
    step("R5", 1'b1, 1'b0, 2'd0, 16'd0);
    for (int i = 0; i < 3; i++) step("R6", 1'b0, 1'b0, 2'd0, 16'd0);
    step("R6", 1'b0, 1'b1, 2'd0, 16'd3);
    for (int i = 0; i < 3; i++) step("R6", 1'b1, 1'b0, 2'd0, 16'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule